// File: doc/BRIEF.md
# Boot-Mode Strap and External Interrupt Front End

This block sits between four active-low external pins and the core. While the chip is held in reset the pins are treated as straps: their levels form a 4-bit boot mode. The block captures that mode into a register on the first clock after reset is released and keeps it for the rest of the session. From then on each pin is an external interrupt request line.

Each request line can be set to detect a falling edge or a low level. Each line has its own enable. An edge-detected request stays pending until the core acknowledges that line. A level-detected request follows the pin. Pin A also drives a wake output that brings the core out of its stop standby state.

Every pin passes through a two-stage synchronizer before use. A three-state sequencer orders the work. HOLD is forced while reset is asserted. HOLD goes to ARM on the first clock after release, and the mode is captured on that transition. ARM goes to RUN on the next clock. RUN is then kept until reset. Request detection and wake run only in RUN.

Top module: `modeirq_frontend`

## Requirements
- R1: A pin change reaches the block's outputs on the third rising clock edge after it is applied, and not on the second.
- R2: On the first clock edge after `rst_n` rises, `boot_mode` takes the synchronized pin levels. Bit 0 is pin A (`pin_n[0]`) and bit 3 is pin D. A pin held high reads as 1. While reset is asserted, `boot_mode` reads 0.
- R3: After capture, `boot_mode` does not change whatever the pins do, until the next reset.
- R4: In edge mode (`cfg_edge[i]`=1), a falling edge on pin i sets pending for line i. Pending stays set after the pin returns high.
- R5: In edge mode, a one-cycle pulse on `ack[i]` clears the pending flag of line i at that clock edge, provided no new falling edge arrives in the same cycle.
- R6: In level mode (`cfg_edge[i]`=0), line i is pending exactly while its synchronized pin is low, and `ack[i]` has no effect on it.
- R7: `irq_req[i]` is line i's pending flag gated by `cfg_enable[i]`. While a line is masked its pending flag is still captured, and it shows as soon as the enable is set.
- R8: `wake` is high one clock after `stop_mode` is high and synchronized pin A is low. This holds whatever `cfg_enable[0]` is. `wake` drops one clock after `stop_mode` falls.
- R9: While reset is asserted, `irq_req` and `wake` are 0. A pin falling during reset, or in the capture clock, records no pending request.
- R10: The sequencer always passes HOLD, then ARM, then RUN, taking one clock per step after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 4 | External active-low pins (bit 0 = pin A) |
| cfg_enable | input | 4 | Per-line request enable |
| cfg_edge | input | 4 | Per-line detection: 1 = falling edge, 0 = low level |
| ack | input | 4 | Per-line acknowledge pulse for edge-mode pending |
| stop_mode | input | 1 | Core is in stop standby |
| boot_mode | output | 4 | Captured boot mode |
| irq_req | output | 4 | Enabled pending requests |
| wake | output | 1 | Request to leave stop standby |

## Verification
The assertions assume that `cfg_edge` is held steady while a line is pending, so that a sticky flag is never reinterpreted as a level. They also assume that reset is asserted at time zero. The bench changes the configuration only after it has cleared all pending flags, and it starts with reset low. It sweeps all sixteen strap values through a reset, with a falling transition placed inside reset. It then runs every line through edge, masked and level cases, and finally checks wake with pin A masked.

// File: rtl/modeirq_pkg.sv
package modeirq_pkg;
    localparam int LINES       = 4;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_t;
endpackage

// File: rtl/modeirq_sync.sv
module modeirq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) chain[s] <= d;
            end else begin : g_next
                always_ff @(posedge clk) chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/modeirq_boot_fsm.sv
module modeirq_boot_fsm
    import modeirq_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] pins_sync,
    output logic              run,
    output logic [MODE_W-1:0] mode
);
    boot_state_t state_q, state_d;
    logic [MODE_W-1:0] mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_ARM;
            ST_ARM:  state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 mode_q <= '0;
        else if (state_q == ST_HOLD) mode_q <= pins_sync;
    end

    assign run  = (state_q == ST_RUN);
    assign mode = mode_q;

    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(mode_q));

    assert_arm_to_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q == ST_RUN));
endmodule

// File: rtl/modeirq_line.sv
module modeirq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic lvl,
    input  logic edge_sel,
    input  logic enable,
    input  logic ack,
    output logic req
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall = prev_q & ~lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (!run)          pend_q <= 1'b0;
            else if (!edge_sel) pend_q <= ~lvl;
            else               pend_q <= fall | (pend_q & ~ack);
        end
    end

    assign req = pend_q & enable;

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pend_q);

    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_sel && pend_q && !ack) |=> pend_q);

    assert_level_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !edge_sel && ack && !lvl) |=> pend_q);
endmodule

// File: rtl/modeirq_frontend.sv
module modeirq_frontend
    import modeirq_pkg::*;
#(
    parameter int N     = LINES,
    parameter int STAGE = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] cfg_enable,
    input  logic [N-1:0] cfg_edge,
    input  logic [N-1:0] ack,
    input  logic         stop_mode,
    output logic [N-1:0] boot_mode,
    output logic [N-1:0] irq_req,
    output logic         wake
);
    logic [N-1:0] pins_s;
    logic         run;
    logic         wake_q;

    modeirq_sync #(.WIDTH(N), .STAGES(STAGE)) u_sync (
        .clk (clk),
        .d   (pin_n),
        .q   (pins_s)
    );

    modeirq_boot_fsm #(.MODE_W(N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_sync (pins_s),
        .run       (run),
        .mode      (boot_mode)
    );

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_line
            modeirq_line u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run),
                .lvl      (pins_s[i]),
                .edge_sel (cfg_edge[i]),
                .enable   (cfg_enable[i]),
                .ack      (ack[i]),
                .req      (irq_req[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= run & stop_mode & ~pins_s[0];
    end

    assign wake = wake_q;

    assert_wake_needs_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(stop_mode));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (irq_req == '0 && !wake));
endmodule

// File: tb/modeirq_frontend_test.sv
`timescale 1ns/1ps
module modeirq_frontend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_n = 4'hF;
    logic [3:0] cfg_enable = 4'hF;
    logic [3:0] cfg_edge = 4'hF;
    logic [3:0] ack = 4'h0;
    logic       stop_mode = 1'b0;
    logic [3:0] boot_mode;
    logic [3:0] irq_req;
    logic       wake;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    modeirq_frontend uut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cfg_enable(cfg_enable),
        .cfg_edge(cfg_edge), .ack(ack), .stop_mode(stop_mode),
        .boot_mode(boot_mode), .irq_req(irq_req), .wake(wake)
    );

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        pin_n = 4'hF;
        step(4);
        ack = 4'hF;
        step(1);
        ack = 4'h0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2, R3, R9, R10: every strap value through a full reset
        for (int m = 0; m < 16; m++) begin
            rst_n = 1'b0;
            pin_n = 4'hF;
            step(2);
            pin_n = m[3:0];
            step(4);
            check("R2 reset value", boot_mode, 4'h0);
            check("R9 quiet in reset", irq_req, 4'h0);
            check("R9 wake in reset", {3'b0, wake}, 4'h0);
            rst_n = 1'b1;
            step(1);
            check("R2 captured mode", boot_mode, m[3:0]);
            step(3);
            check("R9 no spurious edge", irq_req, 4'h0);
            pin_n = ~m[3:0];
            step(5);
            check("R3 mode frozen", boot_mode, m[3:0]);
        end

        cfg_enable = 4'hF;
        cfg_edge = 4'hF;
        clear_all();
        check("R5 cleared start", irq_req, 4'h0);

        for (int i = 0; i < 4; i++) begin
            logic [3:0] bitm;
            bitm = 4'(1 << i);
            // R1 and R4: edge detect with latency
            pin_n = 4'hF & ~bitm;
            step(2);
            check("R1 not before third edge", irq_req, 4'h0);
            step(1);
            check("R1 R4 edge pending", irq_req, bitm);
            pin_n = 4'hF;
            step(4);
            check("R4 sticky", irq_req, bitm);
            ack = bitm;
            step(1);
            ack = 4'h0;
            check("R5 ack clears", irq_req, 4'h0);

            // R7: masked capture
            cfg_enable = 4'hF & ~bitm;
            pin_n = 4'hF & ~bitm;
            step(4);
            check("R7 masked", irq_req, 4'h0);
            cfg_enable = 4'hF;
            #0.5;
            check("R7 unmask shows pending", irq_req, bitm);
            clear_all();

            // R6: level mode
            cfg_edge = 4'hF & ~bitm;
            pin_n = 4'hF & ~bitm;
            step(3);
            check("R6 level pending", irq_req, bitm);
            ack = bitm;
            step(1);
            ack = 4'h0;
            step(1);
            check("R6 ack ignored", irq_req, bitm);
            pin_n = 4'hF;
            step(3);
            check("R6 level released", irq_req, 4'h0);
            cfg_edge = 4'hF;
            clear_all();
        end

        // R8: wake from pin A, independent of its enable
        stop_mode = 1'b1;
        step(3);
        check("R8 no wake while high", {3'b0, wake}, 4'h0);
        cfg_enable = 4'hE;
        pin_n = 4'hE;
        step(3);
        check("R8 wake asserted", {3'b0, wake}, 4'h1);
        check("R8 line A masked", irq_req, 4'h0);
        stop_mode = 1'b0;
        step(1);
        check("R8 wake drops with stop", {3'b0, wake}, 4'h0);
        cfg_enable = 4'hF;
        clear_all();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule